// File: doc/BRIEF.md
# Deferred-Latch Interrupt Cause Controller

This block gathers single-cycle event pulses from timers, DMA channels and similar sources and drives one interrupt line to a CPU. Events are first collected in a hidden pending register. They move into the software-visible cause register only at a clock edge where the interrupt line is low. While the CPU is servicing an interrupt, the cause word it reads stays stable, and no new cause can appear until the line has dropped.

Software clears causes by writing the cause word with zeros in the bits to clear and ones elsewhere. It enables sources through a CPU mask register, in which only some positions can be written. The block keeps two summary bits in the cause word. Bit 0 reports that any cause is present. Bit 30 reports that an unmasked cause is present.

Reads are combinational and take an address. Writes are synchronous.

Top module: `irq_latch_ctrl`

## Requirements
- R1: A write to the cause word (byte address 0xC18) ANDs the write data into the stored causes: a 0 clears that bit and a 1 leaves it unchanged. The result is visible after the same edge.
- R2: A write to the mask word (byte address 0xC1C) stores only the bits in 0x3C1FFFFE. Bits 0, 25:21 and 31:30 always read back as 0.
- R3: While the interrupt output is high, arriving events do not change the cause word. They are held in pending instead.
- R4: At an edge where the interrupt output is low, every pending event and every event arriving in that cycle is ORed into the cause word, and pending is emptied.
- R5: Cause bit 0 is 1 exactly when any other cause bit except bit 30 is 1.
- R6: Cause bit 30 is 1 exactly when cause AND mask AND 0x3C1FFFFE is nonzero.
- R7: The interrupt output is high exactly when cause AND mask is nonzero. It changes at the same edge as the cause word.
- R8: When a cause write drops the output while events are pending, those events enter the cause word at the next edge, and the output is evaluated again at that edge. The output is low for exactly one cycle when they are unmasked.
- R9: An event that arrives in the same cycle as a cause write, while the output is high, is held in pending and is not lost.
- R10: A synchronous reset clears cause, mask and pending and drives the output low.
- R11: Event inputs at bit positions 0 and 30 are ignored, because those positions carry summary bits.
- R12: A read of any address other than the cause and mask words returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| evt_i | input | 32 | Event pulses, one bit per source |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Corrupted pending state stays hidden until the output next drops. It then appears one edge later as a missing or extra cause bit, and often as a missing or extra re-assertion of the output. A corrupted cause or mask register, or a wrong summary computation, appears on the next read of the cause word and at the output after the same edge. The bench therefore compares the output and both registers after every edge, against a model built from the requirements. Directed sequences cover the one-cycle drop, a write coinciding with an event, and the ignored summary positions.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DW = 32;

    // positions software may set in the CPU mask
    localparam logic [DW-1:0] MASK_WRITABLE = 32'h3C1F_FFFE;
    // summary positions inside the cause word
    localparam int SUM_ANY_POS = 0;
    localparam int SUM_CPU_POS = 30;
    // positions that come from event sources
    localparam logic [DW-1:0] SRC_BITS = ~((32'h1 << SUM_ANY_POS) | (32'h1 << SUM_CPU_POS));

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic          to_cause;
        logic          to_mask;
        logic [DW-1:0] data;
    } reg_wr_t;

    // insert both summary bits into a raw cause word
    function automatic logic [DW-1:0] add_summary(input logic [DW-1:0] raw,
                                                  input logic [DW-1:0] msk);
        logic [DW-1:0] res;
        res = raw & SRC_BITS;
        res[SUM_ANY_POS] = |res;
        res[SUM_CPU_POS] = |(res & msk & MASK_WRITABLE);
        return res;
    endfunction

endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
    import intc_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = 12'hC18,
    parameter logic [ADDR_W-1:0] MASK_OFS  = 12'hC1C
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output reg_wr_t           wr,
    output reg_sel_e          rd_sel
);

    always_comb begin
        wr.to_cause = wr_en && (wr_addr == CAUSE_OFS);
        wr.to_mask  = wr_en && (wr_addr == MASK_OFS);
        wr.data     = wr_data;
    end

    always_comb begin
        if (rd_addr == CAUSE_OFS)
            rd_sel = SEL_CAUSE;
        else if (rd_addr == MASK_OFS)
            rd_sel = SEL_MASK;
        else
            rd_sel = SEL_NONE;
    end

endmodule

// File: rtl/intc_pend.sv
module intc_pend
    import intc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [DW-1:0] evt,
    output logic [DW-1:0] pend_q,
    output logic [DW-1:0] pend_all
);

    assign pend_all = pend_q | (evt & SRC_BITS);

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else if (take)
            pend_q <= '0;
        else
            pend_q <= pend_all;
    end

    // R11: summary positions never collect
    p_no_summary_pend_r11: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~SRC_BITS) == '0);

endmodule

// File: rtl/intc_cause.sv
module intc_cause
    import intc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  reg_wr_t       wr,
    input  logic [DW-1:0] pend_all,
    output logic [DW-1:0] cause_q,
    output logic [DW-1:0] mask_q,
    output logic          irq_q
);

    logic [DW-1:0] cause_w;
    logic [DW-1:0] raw;
    logic [DW-1:0] mask_d;
    logic [DW-1:0] cause_d;
    logic          irq_d;

    always_comb begin
        cause_w = wr.to_cause ? (cause_q & wr.data) : cause_q;
        raw     = irq_q ? cause_w : (cause_w | pend_all);
        mask_d  = wr.to_mask ? (wr.data & MASK_WRITABLE) : mask_q;
        cause_d = add_summary(raw, mask_d);
        irq_d   = |(cause_d & mask_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            mask_q  <= mask_d;
            irq_q   <= irq_d;
        end
    end

    p_clear_and_r1: assert property (@(posedge clk) disable iff (rst)
        (wr.to_cause && irq_q) |=>
            ((cause_q & SRC_BITS) == ($past(cause_q) & $past(wr.data) & SRC_BITS)));

    p_mask_store_r2: assert property (@(posedge clk) disable iff (rst)
        wr.to_mask |=> (mask_q == ($past(wr.data) & MASK_WRITABLE)));

    p_hold_high_r3: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> ((cause_q & ~$past(cause_q) & SRC_BITS) == '0));

    p_sum_any_r5: assert property (@(posedge clk) disable iff (rst)
        cause_q[SUM_ANY_POS] == |(cause_q & SRC_BITS));

    p_sum_cpu_r6: assert property (@(posedge clk) disable iff (rst)
        cause_q[SUM_CPU_POS] == |(cause_q & mask_q & MASK_WRITABLE));

    p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
        irq_q == |(cause_q & mask_q));

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import intc_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = 12'hC18,
    parameter logic [ADDR_W-1:0] MASK_OFS  = 12'hC1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [31:0]       evt_i,
    output logic              irq_o
);

    reg_wr_t       wr;
    reg_sel_e      rd_sel;
    logic [DW-1:0] pend_q;
    logic [DW-1:0] pend_all;
    logic [DW-1:0] cause_q;
    logic [DW-1:0] mask_q;

    intc_addr_dec #(
        .ADDR_W   (ADDR_W),
        .CAUSE_OFS(CAUSE_OFS),
        .MASK_OFS (MASK_OFS)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .wr     (wr),
        .rd_sel (rd_sel)
    );

    intc_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .take    (!irq_o),
        .evt     (evt_i),
        .pend_q  (pend_q),
        .pend_all(pend_all)
    );

    intc_cause u_cause (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .pend_all(pend_all),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .irq_q   (irq_o)
    );

    always_comb begin
        case (rd_sel)
            SEL_CAUSE: rd_data = cause_q;
            SEL_MASK:  rd_data = mask_q;
            default:   rd_data = '0;
        endcase
    end

    // R4: everything pending at a low edge lands in cause
    p_merge_low_r4: assert property (@(posedge clk) disable iff (rst)
        !irq_o |=> ((cause_q & $past(pend_q)) == $past(pend_q)));

    // R9: an event seen while high is kept in pending
    p_keep_event_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> ((pend_q & $past(evt_i) & SRC_BITS) == ($past(evt_i) & SRC_BITS)));

    // R10: reset leaves output low and everything empty
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!irq_o && cause_q == '0 && mask_q == '0 && pend_q == '0));

endmodule

// File: tb/test_irq_latch_ctrl.sv
`timescale 1ns/1ps
module test_irq_latch_ctrl;

    localparam logic [11:0] A_CAUSE = 12'hC18;
    localparam logic [11:0] A_MASK  = 12'hC1C;
    localparam logic [31:0] WM      = 32'h3C1F_FFFE;
    localparam logic [31:0] SRC     = 32'hBFFF_FFFE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] evt_i = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_cause = '0, m_mask = '0, m_pend = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    irq_latch_ctrl i_irq_latch_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_i(evt_i), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_summary(input logic [31:0] raw, input logic [31:0] msk);
        logic [31:0] r;
        r = raw & SRC;                 // R11 positions dropped
        r[0]  = |r;                    // R5
        r[30] = |(r & msk & WM);       // R6
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model(input logic we, input logic [11:0] a, input logic [31:0] d,
                         input logic [31:0] e);
        logic [31:0] cw, md, pa, raw;
        cw = (we && a == A_CAUSE) ? (m_cause & d) : m_cause;   // R1
        md = (we && a == A_MASK) ? (d & WM) : m_mask;          // R2
        pa = m_pend | (e & SRC);
        if (!m_irq) begin raw = cw | pa; m_pend = '0; end      // R4
        else begin raw = cw; m_pend = pa; end                  // R3 R9
        m_cause = exp_summary(raw, md);
        m_mask  = md;
        m_irq   = |(m_cause & m_mask);                         // R7
    endtask

    task automatic compare(input string req);
        #0.5 rd_addr = A_CAUSE;
        #0.4 chk({req, " cause"}, rd_data, m_cause);
        rd_addr = A_MASK;
        #0.4 chk({req, " mask"}, rd_data, m_mask);
        chk({req, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
    endtask

    task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] e, input string req);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; evt_i = e;
        @(posedge clk);
        model(we, a, d, e);
        compare(req);
        wr_en = 1'b0; evt_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; evt_i = '0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cause = '0; m_mask = '0; m_pend = '0; m_irq = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        compare("R10 reset");

        // R2 writable mask pattern
        cyc(1'b1, A_MASK, 32'hFFFF_FFFF, '0, "R2 mask all ones");
        chk("R2 mask readback", rd_data, 32'h3C1F_FFFE);

        // R4 R5 R6 R7 first event while low
        cyc(1'b0, '0, '0, 32'h0000_0020, "R4 merge low");
        chk("R7 irq high", {31'd0, irq_o}, 32'd1);
        rd_addr = A_CAUSE; #0.2;
        chk("R5 R6 summaries", rd_data, 32'h4000_0021);

        // R3 new event while high stays hidden
        cyc(1'b0, '0, '0, 32'h0000_0080, "R3 hold high");
        rd_addr = A_CAUSE; #0.2;
        chk("R3 cause unchanged", rd_data, 32'h4000_0021);

        // R1 R8 clear drops line for one cycle, then pending enters
        cyc(1'b1, A_CAUSE, ~32'h0000_0020, '0, "R1 clear");
        chk("R8 irq dropped", {31'd0, irq_o}, 32'd0);
        rd_addr = A_CAUSE; #0.2;
        chk("R1 cause cleared", rd_data, 32'h0);
        cyc(1'b0, '0, '0, '0, "R8 re-eval");
        chk("R8 irq back", {31'd0, irq_o}, 32'd1);
        rd_addr = A_CAUSE; #0.2;
        chk("R8 cause from pending", rd_data, 32'h4000_0081);

        // R9 event with same-cycle clear while high
        cyc(1'b1, A_CAUSE, 32'h0, 32'h0000_0200, "R9 write+event");
        rd_addr = A_CAUSE; #0.2;
        chk("R9 cause after clear", rd_data, 32'h0);
        cyc(1'b0, '0, '0, '0, "R9 kept");
        rd_addr = A_CAUSE; #0.2;
        chk("R9 event kept", rd_data, 32'h4000_0201);

        // R11 summary positions as events
        cyc(1'b1, A_CAUSE, 32'h0, '0, "R11 clear");
        cyc(1'b0, '0, '0, 32'h4000_0001, "R11 ignored");
        rd_addr = A_CAUSE; #0.2;
        chk("R11 cause stays zero", rd_data, 32'h0);

        // masked-off cause: bit0 set, bit30 and irq clear
        cyc(1'b0, '0, '0, 32'h0020_0000, "R6 unmaskable bit");
        rd_addr = A_CAUSE; #0.2;
        chk("R5 R6 unmasked-only", rd_data, 32'h0020_0001);
        chk("R7 irq low", {31'd0, irq_o}, 32'd0);

        // R12 unmapped read
        rd_addr = 12'h800; #0.2;
        chk("R12 other address", rd_data, 32'h0);

        // R10 reset drops pending
        cyc(1'b0, '0, '0, 32'h0000_0004, "R10 pre");
        cyc(1'b0, '0, '0, 32'h0000_0010, "R10 pend");
        do_reset();
        cyc(1'b0, '0, '0, '0, "R10 after reset");
        chk("R10 irq low", {31'd0, irq_o}, 32'd0);

        // random mix against model
        for (int i = 0; i < 600; i++) begin
            logic we;
            logic [11:0] a;
            logic [31:0] d, e;
            we = ($urandom % 4) == 0;
            case ($urandom % 5)
                0: a = A_MASK;
                1: a = 12'h800;
                default: a = A_CAUSE;
            endcase
            d = (a == A_CAUSE) ? ~(32'h1 << ($urandom % 32)) & ~(32'h1 << ($urandom % 32))
                               : $urandom;
            if (($urandom % 8) == 0) d = '0;
            e = (($urandom % 3) == 0) ? (32'h1 << ($urandom % 32)) : '0;
            cyc(we, a, d, e, "R1 R3 R4 R7 random");
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule